// File: doc/BRIEF.md
# Iterative Multi-Mode Divider

This block divides a dividend by a 16-bit divisor and develops one quotient bit per clock. It serves integer and Q15 fractional arithmetic, both signed and unsigned, with a 16-bit or a 32-bit dividend. A single start pulse captures the operands and the mode. The block then runs a fixed number of iteration steps and one finishing cycle. It presents a 16-bit quotient and a 16-bit remainder together with overflow and divide-by-zero flags, and marks completion with a one-cycle done pulse.

The iteration works on magnitudes using non-restoring steps, and the signs are applied in the finishing cycle. A hold input lets a surrounding context freeze the iteration at any point, for example while an interrupt is served. All partial state stays in place and the operation resumes when hold drops. The count of remaining steps lives in an internal down-counter.

Top module: `iter_divider`

## Requirements
- R1: While reset is asserted, and right after it, busy, done, both flags, quotient and remainder are all zero.
- R2: Mode codes are 0 = signed fractional 16/16, 1 = signed 32/16, 2 = unsigned 32/16, 3 = signed 16/16, 4 = unsigned 16/16. Codes 5 to 7 behave as code 4. In the 16/16 and fractional modes, dividend bits 31:16 have no effect on any output.
- R3: A start sampled high while idle at clock edge k raises busy after edge k. Done is high for exactly the one cycle after edge k+19, and busy falls at that same edge.
- R4: A start sampled while busy is ignored: the running operation keeps its operands, its result and its timing.
- R5: Each cycle in which hold is high during busy freezes the operation and delays done by one cycle. The result does not change.
- R6: In the integer modes the quotient is truncated toward zero, the remainder takes the sign of the dividend, and quotient × divisor + remainder = dividend.
- R7: In fractional mode, with x the Q15 dividend (bits 15:0) and y the Q15 divisor, the quotient is trunc(x·2^15 / y) and the remainder is (|x|·2^15 mod |y|), carrying the sign of x.
- R8: The overflow flag is set when the true quotient is above 65535 in the unsigned modes, outside −32768..32767 in the signed integer modes, or of magnitude 32768 or more (|q| ≥ 1.0) in fractional mode. The quotient and remainder values are then unspecified.
- R9: A zero divisor sets the divide-by-zero flag and clears the overflow flag.
- R10: Quotient, remainder and flags are updated only at the edge that raises done and hold their values until the next completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, honoured only while idle |
| hold_i | input | 1 | Freezes a running operation |
| mode_i | input | 3 | Operation mode code |
| dividend_i | input | 32 | Dividend; bits 31:16 used only in 32/16 modes |
| divisor_i | input | 16 | Divisor |
| quotient_o | output | 16 | Quotient of the last completed operation |
| remainder_o | output | 16 | Remainder of the last completed operation |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ovf_o | output | 1 | Quotient does not fit the mode's range |
| dzero_o | output | 1 | Divisor was zero |

## Verification
A wrong step counter or a missed hold shows up as done arriving in the wrong cycle, so every operation's completion cycle is compared with 19 plus the number of held cycles. A corrupted partial remainder or quotient bit does not appear at the ports until the finishing cycle. It then shows as a wrong quotient or remainder on that same done pulse, which is why each result is compared against an independent model across all five modes, signed operand combinations and the range edges. Capture faults, where operands are not latched or a start during busy is taken, are exposed by changing the inputs and pulsing start in the middle of a run.

// File: rtl/itdiv_pkg.sv
package itdiv_pkg;
  typedef enum logic [2:0] {
    MD_FRAC = 3'd0,
    MD_S32  = 3'd1,
    MD_U32  = 3'd2,
    MD_S16  = 3'd3,
    MD_U16  = 3'd4
  } div_mode_e;
endpackage

// File: rtl/itdiv_operand_prep.sv
module itdiv_operand_prep #(
  parameter int DW = 16
) (
  input  logic [2:0]      mode_i,
  input  logic [2*DW-1:0] dvd_i,
  input  logic [DW-1:0]   dvs_i,
  output logic [2*DW-1:0] mag_o,
  output logic [DW-1:0]   dmag_o,
  output logic            neg_q_o,
  output logic            neg_r_o,
  output logic            sgn_o,
  output logic            frac_o,
  output logic            dz_o,
  output logic            pre_ovf_o
);
  import itdiv_pkg::*;

  logic [DW-1:0]   lo, lo_abs, dvs_abs;
  logic [2*DW-1:0] full_abs;
  logic            dvd_neg;

  always_comb begin
    lo       = dvd_i[DW-1:0];
    lo_abs   = lo[DW-1] ? (~lo + 1'b1) : lo;
    full_abs = dvd_i[2*DW-1] ? (~dvd_i + 1'b1) : dvd_i;
    dvs_abs  = dvs_i[DW-1] ? (~dvs_i + 1'b1) : dvs_i;
    sgn_o    = 1'b0;
    frac_o   = 1'b0;
    dvd_neg  = 1'b0;
    case (div_mode_e'(mode_i))
      MD_FRAC: begin
        sgn_o   = 1'b1;
        frac_o  = 1'b1;
        dvd_neg = lo[DW-1];
        mag_o   = {{DW{1'b0}}, lo_abs} << (DW-1);
      end
      MD_S32: begin
        sgn_o   = 1'b1;
        dvd_neg = dvd_i[2*DW-1];
        mag_o   = full_abs;
      end
      MD_U32: mag_o = dvd_i;
      MD_S16: begin
        sgn_o   = 1'b1;
        dvd_neg = lo[DW-1];
        mag_o   = {{DW{1'b0}}, lo_abs};
      end
      default: mag_o = {{DW{1'b0}}, lo};
    endcase
    dmag_o    = sgn_o ? dvs_abs : dvs_i;
    neg_r_o   = dvd_neg;
    neg_q_o   = dvd_neg ^ (sgn_o & dvs_i[DW-1]);
    dz_o      = (dvs_i == '0);
    pre_ovf_o = !dz_o && (mag_o[2*DW-1:DW] >= dmag_o);
  end
endmodule

// File: rtl/itdiv_nr_step.sv
module itdiv_nr_step #(
  parameter int DW = 16,
  parameter int PW = DW + 4
) (
  input  logic [PW-1:0] p_i,
  input  logic          bit_i,
  input  logic [DW-1:0] d_i,
  output logic [PW-1:0] p_o,
  output logic          q_o
);
  logic [PW-1:0] shifted, dx;

  always_comb begin
    shifted = {p_i[PW-2:0], bit_i};
    dx      = {{(PW-DW){1'b0}}, d_i};
    p_o     = p_i[PW-1] ? (shifted + dx) : (shifted - dx);
    q_o     = ~p_o[PW-1];
  end
endmodule

// File: rtl/itdiv_result_fix.sv
module itdiv_result_fix #(
  parameter int DW = 16,
  parameter int PW = DW + 4
) (
  input  logic [PW-1:0] p_i,
  input  logic [DW-1:0] q_i,
  input  logic [DW-1:0] d_i,
  input  logic          neg_q_i,
  input  logic          neg_r_i,
  input  logic          sgn_i,
  input  logic          frac_i,
  input  logic          pre_ovf_i,
  input  logic          dz_i,
  output logic [DW-1:0] rmag_o,
  output logic [DW-1:0] quo_o,
  output logic [DW-1:0] rem_o,
  output logic          ovf_o
);
  logic [PW-1:0] fixed;
  logic          range_bad;

  always_comb begin
    fixed     = p_i[PW-1] ? (p_i + {{(PW-DW){1'b0}}, d_i}) : p_i;
    rmag_o    = fixed[DW-1:0];
    quo_o     = neg_q_i ? (~q_i + 1'b1) : q_i;
    rem_o     = neg_r_i ? (~rmag_o + 1'b1) : rmag_o;
    range_bad = sgn_i && q_i[DW-1] && (frac_i || !neg_q_i || (q_i[DW-2:0] != '0));
    ovf_o     = !dz_i && (pre_ovf_i || range_bad);
  end
endmodule

// File: rtl/iter_divider.sv
module iter_divider #(
  parameter int DW    = 16,
  parameter int NSTEP = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            hold_i,
  input  logic [2:0]      mode_i,
  input  logic [2*DW-1:0] dividend_i,
  input  logic [DW-1:0]   divisor_i,
  output logic [DW-1:0]   quotient_o,
  output logic [DW-1:0]   remainder_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            ovf_o,
  output logic            dzero_o
);
  localparam int PW  = DW + 4;
  localparam int CW  = $clog2(NSTEP + 1);
  localparam int LOW = 2*DW - NSTEP;

  // operand preparation
  logic [2*DW-1:0] mag;
  logic [DW-1:0]   dmag;
  logic            p_negq, p_negr, p_sgn, p_frac, p_dz, p_povf;

  itdiv_operand_prep #(.DW(DW)) prep_i (
    .mode_i(mode_i), .dvd_i(dividend_i), .dvs_i(divisor_i),
    .mag_o(mag), .dmag_o(dmag), .neg_q_o(p_negq), .neg_r_o(p_negr),
    .sgn_o(p_sgn), .frac_o(p_frac), .dz_o(p_dz), .pre_ovf_o(p_povf)
  );

  // state
  logic            busy_q, busy_d, done_q, done_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [PW-1:0]   p_q, p_d;
  logic [NSTEP-1:0] a_q, a_d, qa_q, qa_d;
  logic [DW-1:0]   d_q;
  logic            negq_q, negr_q, sgn_q, frac_q, dz_q, povf_q;
  logic [DW-1:0]   quo_q, rem_q;
  logic            ovf_q, dzo_q;

  logic start_ok, adv, step_en, fin_en;
  logic [PW-1:0] p_step;
  logic          q_bit;
  logic [DW-1:0] f_rmag, f_quo, f_rem;
  logic          f_ovf;

  itdiv_nr_step #(.DW(DW), .PW(PW)) step_i (
    .p_i(p_q), .bit_i(a_q[NSTEP-1]), .d_i(d_q), .p_o(p_step), .q_o(q_bit)
  );

  itdiv_result_fix #(.DW(DW), .PW(PW)) fix_i (
    .p_i(p_q), .q_i(qa_q[DW-1:0]), .d_i(d_q), .neg_q_i(negq_q), .neg_r_i(negr_q),
    .sgn_i(sgn_q), .frac_i(frac_q), .pre_ovf_i(povf_q), .dz_i(dz_q),
    .rmag_o(f_rmag), .quo_o(f_quo), .rem_o(f_rem), .ovf_o(f_ovf)
  );

  // next state
  always_comb begin
    start_ok = start_i && !busy_q;
    adv      = busy_q && !hold_i;
    step_en  = adv && (cnt_q != '0);
    fin_en   = adv && (cnt_q == '0);
    busy_d   = busy_q;
    cnt_d    = cnt_q;
    p_d      = p_q;
    a_d      = a_q;
    qa_d     = qa_q;
    if (start_ok) begin
      busy_d = 1'b1;
      cnt_d  = CW'(NSTEP);
      p_d    = {{(PW-LOW){1'b0}}, mag[2*DW-1:NSTEP]};
      a_d    = mag[NSTEP-1:0];
      qa_d   = '0;
    end else if (step_en) begin
      cnt_d  = cnt_q - 1'b1;
      p_d    = p_step;
      a_d    = {a_q[NSTEP-2:0], 1'b0};
      qa_d   = {qa_q[NSTEP-2:0], q_bit};
    end else if (fin_en) begin
      busy_d = 1'b0;
    end
    done_d = fin_en;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      p_q    <= '0;
      a_q    <= '0;
      qa_q   <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
      p_q    <= p_d;
      a_q    <= a_d;
      qa_q   <= qa_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_q    <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      sgn_q  <= 1'b0;
      frac_q <= 1'b0;
      dz_q   <= 1'b0;
      povf_q <= 1'b0;
    end else if (start_ok) begin
      d_q    <= dmag;
      negq_q <= p_negq;
      negr_q <= p_negr;
      sgn_q  <= p_sgn;
      frac_q <= p_frac;
      dz_q   <= p_dz;
      povf_q <= p_povf;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_q <= '0;
      rem_q <= '0;
      ovf_q <= 1'b0;
      dzo_q <= 1'b0;
    end else if (fin_en) begin
      quo_q <= f_quo;
      rem_q <= f_rem;
      ovf_q <= f_ovf;
      dzo_q <= dz_q;
    end
  end

  assign quotient_o  = quo_q;
  assign remainder_o = rem_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign ovf_o       = ovf_q;
  assign dzero_o     = dzo_q;

  // checks
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !hold_i && cnt_q != '0) |=> (busy_q && cnt_q == CW'($past(cnt_q) - 1'b1)));
  assert_hold_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && hold_i) |=> (busy_q && $stable(cnt_q) && $stable(p_q) && $stable(qa_q)));
  assert_start_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> ($stable(d_q) && $stable(negq_q) && $stable(negr_q)));
  assert_rem_below_div_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_en && !dz_q && !povf_q) |-> (f_rmag < d_q));
  assert_flag_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !(ovf_q && dzo_q));
endmodule

// File: tb/iter_divider_tb_top.sv
`timescale 1ns/1ps
module iter_divider_tb_top;
  logic        clk, rst_n, start_i, hold_i;
  logic [2:0]  mode_i;
  logic [31:0] dividend_i;
  logic [15:0] divisor_i;
  logic [15:0] quotient_o, remainder_o;
  logic        busy_o, done_o, ovf_o, dzero_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  iter_divider dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .hold_i(hold_i), .mode_i(mode_i),
    .dividend_i(dividend_i), .divisor_i(divisor_i), .quotient_o(quotient_o),
    .remainder_o(remainder_o), .busy_o(busy_o), .done_o(done_o), .ovf_o(ovf_o),
    .dzero_o(dzero_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    wait (cyc >= 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
    finish_run();
  end

  // reference model from the requirements
  task automatic model(input logic [2:0] md, input logic [31:0] dvd, input logic [15:0] dvs,
                       output logic [15:0] eq, output logic [15:0] er,
                       output logic eov, output logic edz);
    longint n, d, q, r;
    case (md)
      3'd0: begin n = longint'($signed(dvd[15:0])) * 32768; d = longint'($signed(dvs)); end
      3'd1: begin n = longint'($signed(dvd));                d = longint'($signed(dvs)); end
      3'd2: begin n = longint'({32'd0, dvd});                d = longint'({48'd0, dvs}); end
      3'd3: begin n = longint'($signed(dvd[15:0]));          d = longint'($signed(dvs)); end
      default: begin n = longint'({48'd0, dvd[15:0]});       d = longint'({48'd0, dvs}); end
    endcase
    edz = (dvs == 16'd0);
    eq = '0; er = '0; eov = 1'b0;
    if (!edz) begin
      q = n / d;
      r = n % d;
      eq = q[15:0];
      er = r[15:0];
      if (md == 3'd0)                    eov = (q >= 32768) || (q <= -32768);
      else if (md == 3'd1 || md == 3'd3) eov = (q > 32767) || (q < -32768);
      else                               eov = (q > 65535);
    end
  endtask

  task automatic run_op(input logic [2:0] md, input logic [31:0] dvd, input logic [15:0] dvs,
                        input int hold_pct, input bit poke, input string tag);
    logic [15:0] eq, er;
    logic        eov, edz;
    int          holds, j;
    bit          seen;
    string       rq;
    logic [15:0] q0, r0;
    model(md, dvd, dvs, eq, er, eov, edz);
    rq = (md == 3'd0) ? "R7" : "R6";
    @(negedge clk);
    mode_i = md; dividend_i = dvd; divisor_i = dvs; start_i = 1'b1; hold_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    // scramble inputs: operands must already be captured
    mode_i = 3'($urandom); dividend_i = $urandom; divisor_i = 16'($urandom);
    holds = 0; j = 0; seen = 1'b0;
    while (j < 400) begin
      if (done_o) begin seen = 1'b1; break; end
      if (!busy_o) begin
        chk(1'b0, "R3", {tag, " busy during run"}, 0, 1);
        break;
      end
      hold_i  = ($urandom % 100) < hold_pct;
      if (hold_i) holds++;
      start_i = poke && (j == 4);
      @(negedge clk);
      j++;
    end
    hold_i = 1'b0; start_i = 1'b0;
    chk(seen && j == 19 + holds, holds > 0 ? "R5" : "R3",
        {tag, " done cycle"}, j, 19 + holds);
    chk(!busy_o, "R3", {tag, " busy low at done"}, busy_o, 0);
    chk(dzero_o == edz, "R9", {tag, " dzero flag"}, dzero_o, edz);
    chk(ovf_o == eov, edz ? "R9" : "R8", {tag, " overflow flag"}, ovf_o, eov);
    if (!edz && !eov) begin
      chk(quotient_o == eq, rq, {tag, " quotient"}, quotient_o, eq);
      chk(remainder_o == er, rq, {tag, " remainder"}, remainder_o, er);
    end
    q0 = quotient_o; r0 = remainder_o;
    @(negedge clk);
    chk(!done_o, "R3", {tag, " done one cycle"}, done_o, 0);
    chk(quotient_o == q0 && remainder_o == r0, "R10", {tag, " result held"},
        quotient_o, q0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; hold_i = 1'b0;
    mode_i = '0; dividend_i = '0; divisor_i = '0;
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, ovf_o, dzero_o} == 4'b0, "R1", "status in reset",
        {busy_o, done_o, ovf_o, dzero_o}, 0);
    chk(quotient_o == 0 && remainder_o == 0, "R1", "result in reset", quotient_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !done_o, "R1", "idle after reset", busy_o, 0);

    // directed corners
    run_op(3'd4, 32'd100, 16'd7, 0, 0, "R6 u16");
    run_op(3'd3, 32'h0000_FF9C, 16'd7, 0, 0, "R6 s16 neg dividend");
    run_op(3'd3, 32'd100, 16'hFFF9, 0, 0, "R6 s16 neg divisor");
    run_op(3'd1, 32'hFFF0_BDC0, 16'd300, 0, 0, "R6 s32");
    run_op(3'd2, 32'h0012_3456, 16'h1234, 0, 0, "R6 u32");
    run_op(3'd2, 32'h1000_0000, 16'd2, 0, 0, "R8 u32 overflow");
    run_op(3'd3, 32'h0000_8000, 16'hFFFF, 0, 0, "R8 s16 -32768/-1");
    run_op(3'd3, 32'h0000_8000, 16'd1, 0, 0, "R8 s16 -32768/1 fits");
    run_op(3'd1, 32'h7FFF_0000, 16'h7FFF, 0, 0, "R8 s32 just over");
    run_op(3'd0, 32'h0000_2000, 16'h4000, 0, 0, "R7 frac 0.25/0.5");
    run_op(3'd0, 32'h0000_E000, 16'h4000, 0, 0, "R7 frac -0.25/0.5");
    run_op(3'd0, 32'h0000_1234, 16'hC567, 0, 0, "R7 frac mixed");
    run_op(3'd0, 32'h0000_C000, 16'h4000, 0, 0, "R8 frac -1.0");
    run_op(3'd0, 32'h0000_4000, 16'h4000, 0, 0, "R8 frac 1.0");
    run_op(3'd3, 32'd55, 16'd0, 0, 0, "R9 zero divisor");
    run_op(3'd4, 32'hDEAD_0064, 16'd7, 0, 0, "R2 upper half ignored");
    run_op(3'd0, 32'hBEEF_1000, 16'h7000, 0, 0, "R2 frac upper half ignored");
    run_op(3'd7, 32'h0000_FFFF, 16'd3, 0, 0, "R2 code 7 as unsigned 16");
    run_op(3'd4, 32'd60000, 16'd13, 60, 0, "R5 heavy hold");
    run_op(3'd1, 32'h8000_0000, 16'hFFFF, 0, 1, "R4 start while busy");
    run_op(3'd2, 32'hFFFE_0001, 16'hFFFF, 30, 1, "R4 R5 u32 max");

    // constrained random
    for (int i = 0; i < 300; i++) begin
      logic [2:0]  md;
      logic [31:0] dv;
      logic [15:0] ds;
      md = 3'($urandom % 6);
      dv = $urandom;
      if ((md == 3'd1 || md == 3'd2) && ($urandom % 4 != 0)) dv = dv >> ($urandom % 24 + 8);
      ds = 16'($urandom);
      if ($urandom % 8 == 0) ds = 16'($urandom % 4);
      run_op(md, dv, ds, 20, ($urandom % 5) == 0, "R6 R7 random");
    end
    finish_run();
  end
endmodule